// File: doc/BRIEF.md
# Sixteen-Bit ALU with Relation and Status Flags

This block is the arithmetic core of a small word-oriented processor. One operand pair, an operation select and a shift-mode field enter each cycle; the 16-bit result leaves combinationally in the same cycle. The block offers addition, subtraction, the three bitwise logic operations, a shifter with several modes, and a signed compare.

A four-bit flag register sits beside the datapath. The upper pair holds a relation code written by compare. The lower pair holds overflow and carry, written by add, subtract and shift. The register loads only on a clock edge where the update enable is high. A condition evaluator reads the stored flags and reports whether a selected branch condition holds. A sequencer uses this signal to choose the next program counter.

Top module: `alu16_flags`

## Requirements
- R1: Operation code 0 (add) drives `result` = a+b mod 2^16. When the flags update, bit 0 (c) takes the carry out of bit 15 and bit 1 (v) takes signed overflow.
- R2: Operation code 1 (sub) drives `result` = a-b mod 2^16. When the flags update, c is set on an unsigned borrow (a < b unsigned) and v on signed overflow.
- R3: Operation codes 2, 3 and 4 drive a AND b, a OR b and a XOR b. They leave all four flag bits unchanged even with the update enable high.
- R4: Operation code 6 (compare) drives `result` = 0. With the enable high it writes flags[3:2] with the signed relation of a to b: 10 for less, 01 for equal, 00 for greater. It leaves flags[1:0] unchanged. Add, subtract and shift leave flags[3:2] unchanged.
- R5: Operation code 5 (shift) moves `a` by `b[3:0]` places; b[15:4] is ignored. `shmode` bit 3 selects left (1) or right (0), bit 2 selects rotate, bit 1 adds the carry flag to the rotate path, and bit 0 selects arithmetic fill on a right plain shift.
- R6: A plain shift fills with zeros, except that an arithmetic right shift copies the sign bit. c takes the last bit moved out, or 0 when the amount is 0.
- R7: A rotate without carry rotates 16 bits, and c takes the last bit carried around. A rotate with carry rotates the 17-bit value formed by c and `a`. With an amount of 0, c is kept.
- R8: On a shift, v is set when result bit 15 differs from a bit 15.
- R9: The flags load only on a clock edge with `flag_we` high. A synchronous `rst` clears them to 0000.
- R10: `cond` codes are 0 lt, 1 eq, 2 le, 3 gt, 4 v, 5 c, 6 v-or-c and 7 never. lt holds when flags[3] is 1, eq when flags[2] is 1, le when flags[3:2] is not 00, and gt when it is 00. `taken` reflects the stored flags.
- R11: Operation code 7 drives `result` = 0 and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flags |
| op | input | 3 | Operation select |
| a | input | 16 | First operand |
| b | input | 16 | Second operand, or shift amount in bits 3:0 |
| shmode | input | 4 | Shift mode: direction, rotate, carry-include, arithmetic |
| flag_we | input | 1 | Flag register load enable |
| cond | input | 3 | Branch condition select |
| result | output | 16 | Combinational result |
| flags | output | 4 | {relation[1:0], v, c} |
| taken | output | 1 | Selected condition holds on the stored flags |

## Verification
On every cycle the assertions check the following. The flags hold while the enable is low. Logic operations and op 7 never touch the flags. Compare never stores code 11 and never disturbs v or c. Add, subtract and shift never disturb the relation pair. The add result matches the operand sum, and reset clears the flags. The exact shift results, carry-out choice, overflow on shifts, and the mapping from stored codes to each branch condition need specific operand patterns. Only the directed scenarios in the bench show those.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
  typedef enum logic [2:0] {
    OP_ADD = 3'd0, OP_SUB = 3'd1, OP_AND = 3'd2, OP_OR = 3'd3,
    OP_XOR = 3'd4, OP_SHF = 3'd5, OP_CMP = 3'd6, OP_NOP = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    CC_LT = 3'd0, CC_EQ = 3'd1, CC_LE = 3'd2, CC_GT = 3'd3,
    CC_V  = 3'd4, CC_C  = 3'd5, CC_VC = 3'd6, CC_NEVER = 3'd7
  } cond_e;

  localparam logic [1:0] REL_LESS    = 2'b10;
  localparam logic [1:0] REL_EQUAL   = 2'b01;
  localparam logic [1:0] REL_GREATER = 2'b00;

  // shift-mode bit positions
  localparam int SM_LEFT  = 3;
  localparam int SM_ROT   = 2;
  localparam int SM_CARRY = 1;
  localparam int SM_ARITH = 0;
endpackage

// File: rtl/alu16_addlog.sv
module alu16_addlog
  import alu16_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         ovf,
  output logic [1:0]   rel
);
  logic [W:0] sum_x, dif_x;

  always_comb begin
    sum_x = {1'b0, a} + {1'b0, b};
    dif_x = {1'b0, a} - {1'b0, b};
    res   = '0;
    cout  = 1'b0;
    ovf   = 1'b0;
    unique case (alu_op_e'(op))
      OP_ADD: begin
        res  = sum_x[W-1:0];
        cout = sum_x[W];
        ovf  = (a[W-1] == b[W-1]) && (sum_x[W-1] != a[W-1]);
      end
      OP_SUB: begin
        res  = dif_x[W-1:0];
        cout = dif_x[W];
        ovf  = (a[W-1] != b[W-1]) && (dif_x[W-1] != a[W-1]);
      end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      default: res = '0;
    endcase
    if ($signed(a) < $signed(b))       rel = REL_LESS;
    else if (a == b)                   rel = REL_EQUAL;
    else                               rel = REL_GREATER;
  end
endmodule

// File: rtl/alu16_shifter.sv
module alu16_shifter
  import alu16_pkg::*;
#(
  parameter int W  = 16,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  a,
  input  logic [SW-1:0] amt,
  input  logic [3:0]    mode,
  input  logic          cin,
  output logic [W-1:0]  res,
  output logic          cout,
  output logic          ovf
);
  logic [W-1:0] val;
  logic         cy;
  logic         fill;

  always_comb begin
    val  = a;
    cy   = mode[SM_ROT] && mode[SM_CARRY] ? cin : 1'b0;
    fill = 1'b0;
    for (int i = 0; i < W - 1; i++) begin
      if (i < int'(amt)) begin
        if (mode[SM_LEFT]) begin
          if (mode[SM_ROT]) fill = mode[SM_CARRY] ? cy : val[W-1];
          else              fill = 1'b0;
          cy  = val[W-1];
          val = {val[W-2:0], fill};
        end else begin
          if (mode[SM_ROT])        fill = mode[SM_CARRY] ? cy : val[0];
          else if (mode[SM_ARITH]) fill = val[W-1];
          else                     fill = 1'b0;
          cy  = val[0];
          val = {fill, val[W-1:1]};
        end
      end
    end
    res  = val;
    cout = cy;
    ovf  = val[W-1] != a[W-1];
  end
endmodule

// File: rtl/alu16_flagreg.sv
module alu16_flagreg
  import alu16_pkg::*;
#(
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [2:0]    op,
  input  logic [1:0]    rel,
  input  logic          ar_c,
  input  logic          ar_v,
  input  logic          sh_c,
  input  logic          sh_v,
  output logic [FW-1:0] flags
);
  logic [FW-1:0] nxt;

  always_comb begin
    nxt = flags;
    unique case (alu_op_e'(op))
      OP_ADD, OP_SUB: nxt[1:0] = {ar_v, ar_c};
      OP_SHF:         nxt[1:0] = {sh_v, sh_c};
      OP_CMP:         nxt[3:2] = rel;
      default:        nxt = flags;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)     flags <= '0;
    else if (we) flags <= nxt;
  end
endmodule

// File: rtl/alu16_cond.sv
module alu16_cond
  import alu16_pkg::*;
(
  input  logic [3:0] flags,
  input  logic [2:0] cond,
  output logic       taken
);
  always_comb begin
    unique case (cond_e'(cond))
      CC_LT:   taken = flags[3];
      CC_EQ:   taken = flags[2];
      CC_LE:   taken = |flags[3:2];
      CC_GT:   taken = ~|flags[3:2];
      CC_V:    taken = flags[1];
      CC_C:    taken = flags[0];
      CC_VC:   taken = |flags[1:0];
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu16_flags.sv
module alu16_flags
  import alu16_pkg::*;
#(
  parameter int W  = 16,
  parameter int SW = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [2:0]   op,
  input  logic [15:0]  a,
  input  logic [15:0]  b,
  input  logic [3:0]   shmode,
  input  logic         flag_we,
  input  logic [2:0]   cond,
  output logic [15:0]  result,
  output logic [3:0]   flags,
  output logic         taken
);
  logic [W-1:0] al_res, sh_res;
  logic         al_c, al_v, sh_c, sh_v;
  logic [1:0]   rel;

  alu16_addlog #(.W(W)) u_addlog (
    .op(op), .a(a), .b(b), .res(al_res), .cout(al_c), .ovf(al_v), .rel(rel)
  );

  alu16_shifter #(.W(W), .SW(SW)) u_shift (
    .a(a), .amt(b[SW-1:0]), .mode(shmode), .cin(flags[0]),
    .res(sh_res), .cout(sh_c), .ovf(sh_v)
  );

  alu16_flagreg #(.FW(4)) u_flags (
    .clk(clk), .rst(rst), .we(flag_we), .op(op), .rel(rel),
    .ar_c(al_c), .ar_v(al_v), .sh_c(sh_c), .sh_v(sh_v), .flags(flags)
  );

  alu16_cond u_cond (.flags(flags), .cond(cond), .taken(taken));

  always_comb begin
    unique case (alu_op_e'(op))
      OP_SHF:         result = sh_res;
      OP_CMP, OP_NOP: result = '0;
      default:        result = al_res;
    endcase
  end
endmodule

// File: rtl/alu16_flags_chk.sv
module alu16_flags_chk (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  op,
  input logic [15:0] a,
  input logic [15:0] b,
  input logic        flag_we,
  input logic [15:0] result,
  input logic [3:0]  flags
);
  logic rst_q = 1'b0;
  always_ff @(posedge clk) rst_q <= rst;

  always @(negedge clk)
    if (rst_q) AST_RESET_CLEAR: assert (flags == 4'b0000); // R9

  AST_HOLD_NO_WE: assert property (@(posedge clk) disable iff (rst)
    !flag_we |=> $stable(flags)); // R9

  AST_LOGIC_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd2 || op == 3'd3 || op == 3'd4 || op == 3'd7) |=> $stable(flags)); // R3

  AST_CMP_CODE: assert property (@(posedge clk) disable iff (rst)
    (flag_we && op == 3'd6) |=> (flags[3:2] != 2'b11 && flags[1:0] == $past(flags[1:0]))); // R4

  AST_ARITH_KEEPS_REL: assert property (@(posedge clk) disable iff (rst)
    (op == 3'd0 || op == 3'd1 || op == 3'd5) |=> flags[3:2] == $past(flags[3:2])); // R4

  AST_ADD_SUM: assert property (@(posedge clk) disable iff (rst)
    op == 3'd0 |-> result == 16'(a + b)); // R1
endmodule

bind alu16_flags alu16_flags_chk u_chk (
  .clk(clk), .rst(rst), .op(op), .a(a), .b(b), .flag_we(flag_we),
  .result(result), .flags(flags)
);

// File: tb/sim_alu16_flags.sv
module sim_alu16_flags;
  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  op;
  logic [15:0] a, b;
  logic [3:0]  shmode;
  logic        flag_we;
  logic [2:0]  cond;
  logic [15:0] result;
  logic [3:0]  flags;
  logic        taken;
  int n_run = 0, n_fail = 0;
  logic [3:0] ef;

  always #2.5 clk = ~clk;

  alu16_flags u0 (.clk(clk), .rst(rst), .op(op), .a(a), .b(b), .shmode(shmode),
    .flag_we(flag_we), .cond(cond), .result(result), .flags(flags), .taken(taken));

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: run did not finish (got hang, expected end)");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive at negedge, check result, clock once, check flags
  task automatic run(string tag, logic [2:0] o, logic [15:0] x, logic [15:0] y,
                     logic [3:0] m, logic we, logic [15:0] eres, logic [3:0] eflg);
    @(negedge clk);
    op = o; a = x; b = y; shmode = m; flag_we = we;
    #1 chk({tag, " result"}, result, eres);
    @(posedge clk); #1;
    chk({tag, " flags"}, {12'd0, flags}, {12'd0, eflg});
    flag_we = 1'b0; op = 3'd7;
  endtask

  task automatic t_reset();
    rst = 1'b1; op = 3'd7; a = 0; b = 0; shmode = 0; flag_we = 0; cond = 0;
    repeat (2) @(posedge clk); #1;
    chk("R9 reset flags", {12'd0, flags}, 16'h0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_add_sub();
    run("R1 add ovf",   3'd0, 16'h7FFF, 16'h0001, 4'h0, 1, 16'h8000, 4'b0010);
    run("R1 add carry", 3'd0, 16'hFFFF, 16'h0001, 4'h0, 1, 16'h0000, 4'b0001);
    run("R2 sub borrow",3'd1, 16'h0003, 16'h0005, 4'h0, 1, 16'hFFFE, 4'b0001);
    run("R2 sub ovf",   3'd1, 16'h8000, 16'h0001, 4'h0, 1, 16'h7FFF, 4'b0010);
    run("R9 no we",     3'd0, 16'hFFFF, 16'h0001, 4'h0, 0, 16'h0000, 4'b0010);
  endtask

  task automatic t_logic();
    run("R3 and", 3'd2, 16'hF0F0, 16'h3C3C, 4'h0, 1, 16'h3030, 4'b0010);
    run("R3 or",  3'd3, 16'hF0F0, 16'h3C3C, 4'h0, 1, 16'hFCFC, 4'b0010);
    run("R3 xor", 3'd4, 16'hF0F0, 16'h3C3C, 4'h0, 1, 16'hCCCC, 4'b0010);
    run("R11 nop",3'd7, 16'h1234, 16'h4321, 4'h0, 1, 16'h0000, 4'b0010);
  endtask

  task automatic cond_all(string tag, logic [6:0] exp);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk); cond = 3'(k);
      #1 chk($sformatf("R10 %s cond %0d", tag, k), {15'd0, taken},
             {15'd0, (k < 7) ? exp[k] : 1'b0});
    end
  endtask

  task automatic t_compare();
    run("R4 cmp lt", 3'd6, 16'hFFFF, 16'h0001, 4'h0, 1, 16'h0000, 4'b1010);
    cond_all("lt v", 7'b1010101);
    run("R4 cmp eq", 3'd6, 16'h0005, 16'h0005, 4'h0, 1, 16'h0000, 4'b0110);
    cond_all("eq v", 7'b1010110);
    run("R4 cmp gt", 3'd6, 16'h0007, 16'h0002, 4'h0, 1, 16'h0000, 4'b0010);
    cond_all("gt v", 7'b1011000);
  endtask

  task automatic t_shift();
    run("R6 shl",       3'd5, 16'h8001, 16'h0001, 4'b1000, 1, 16'h0002, 4'b0011);
    run("R6 shr log",   3'd5, 16'h8001, 16'h0004, 4'b0000, 1, 16'h0800, 4'b0010);
    run("R6 shr arith", 3'd5, 16'h8001, 16'h0001, 4'b0001, 1, 16'hC000, 4'b0001);
    run("R7 rol",       3'd5, 16'h8001, 16'h0004, 4'b1100, 1, 16'h0018, 4'b0010);
    run("R6 amt0",      3'd5, 16'h1234, 16'h0000, 4'b0000, 1, 16'h1234, 4'b0000);
    run("R5 amt hi ign",3'd5, 16'h1234, 16'h0013, 4'b0000, 1, 16'h0246, 4'b0001);
    run("R7 rcl in",    3'd5, 16'h0000, 16'h0001, 4'b1110, 1, 16'h0001, 4'b0000);
    run("R7 rcl out",   3'd5, 16'h8000, 16'h0001, 4'b1110, 1, 16'h0000, 4'b0011);
    run("R7 rcr",       3'd5, 16'h0002, 16'h0002, 4'b0110, 1, 16'h4000, 4'b0001);
    run("R7 rc amt0",   3'd5, 16'h00FF, 16'h0000, 4'b0110, 1, 16'h00FF, 4'b0001);
    run("R8 sign kept", 3'd5, 16'h4000, 16'h0001, 4'b1000, 1, 16'h8000, 4'b0010);
  endtask

  initial begin
    t_reset();
    t_add_sub();
    t_logic();
    t_compare();
    t_shift();
    t_reset();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule